// File: doc/BRIEF.md
# Framed detector data receiver

This block takes the word stream of a detector link. One word arrives each clock. Each word carries a 2-bit frame code and a 16-bit data field. The frame code marks idle words, the first word of a data block, words inside a block, and the last word of a block. Every word that is not idle has its data field pushed into an internal first-in first-out store. A host DMA path drains that store through a show-ahead read port.

While it receives, the block keeps a running count of the bytes written to the store. It packs this count and a set of flags into one 32-bit status word. The flags are: a block has started, a block is done, the store is full, the store is empty, the transfer mode, and a block is in progress. When a start word or a last word is accepted, the block raises a one-cycle strobe. A downstream event indexer uses these strobes to find event boundaries. A word that arrives while the store is full is dropped, and a sticky overflow indicator records the loss.

Top module: `frame_rx`

## Requirements
- R1: The input `rst` is a synchronous reset, active high. While it is applied, the status word reads 0x10000000 with `mode_dma` low, which means the byte count is zero, bit 28 (empty) is 1 and every other flag is 0. It also clears `ovf_seen` and both strobes, and it empties the store (`rd_valid` = 0).
- R2: A word with frame code 2'b00 is idle. It is not written to the store, and it changes neither the byte count nor any flag.
- R3: A word with frame code 2'b10 (start), 2'b01 (data) or 2'b11 (last) that arrives while the store is not full has its 16-bit data field written to the store. The words are read back on `rd_data` in arrival order. `rd_data` is valid whenever `rd_valid` is 1, and asserting `rd_en` removes the head word at the clock edge.
- R4: Each word written adds 2 to the byte count in status bits 25:0, modulo 2^26. The new count is visible from the clock edge that samples the word.
- R5: A non-idle word that arrives while the store is full is dropped. The store contents and the byte count stay unchanged, and `ovf_seen` rises and stays at 1 until reset. A write in the same cycle as a read of a full store is also dropped.
- R6: The status word is arranged as follows: bit 31 start seen, bit 30 done, bit 29 full, bit 28 empty, bit 27 mode, bit 26 block in progress, bits 25:0 byte count.
- R7: An accepted start word sets bit 31 and bit 26 and clears bit 30. During the following cycle it pulses `sof_pulse` high for exactly one cycle.
- R8: An accepted last word sets bit 30 and clears bit 26. During the following cycle it pulses `eof_pulse` high for exactly one cycle.
- R9: Status bit 27 follows the `mode_dma` input. A value of 0 means program mode and a value of 1 means DMA on demand.
- R10: Status bit 29 is 1 exactly when the store holds DEPTH words (8 by default), and bit 28 is 1 exactly when it holds none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_code | input | 2 | Frame code of the incoming word |
| in_data | input | 16 | Data field of the incoming word |
| mode_dma | input | 1 | Transfer mode: 0 program, 1 DMA on demand |
| rd_en | input | 1 | Removes the head word of the store |
| rd_data | output | 16 | Head word of the store (show-ahead) |
| rd_valid | output | 1 | The store holds at least one word |
| status | output | 32 | Packed flags and byte count |
| sof_pulse | output | 1 | One-cycle strobe after an accepted start word |
| eof_pulse | output | 1 | One-cycle strobe after an accepted last word |
| ovf_seen | output | 1 | Sticky: a word was dropped because the store was full |

## Verification
The assertions assume that `in_code` and `in_data` change only away from the rising edge and hold a defined two-bit code at each edge. They also assume that `rd_en` is asserted only while `rd_valid` is high. The bench drives every input on the falling edge and calls its read task only after it has confirmed `rd_valid`. Because of that, no pop of an empty store is ever requested. The bench also never lets a word race the sampling edge.

// File: rtl/frx_pkg.sv
package frx_pkg;

  typedef enum logic [1:0] {
    FC_IDLE  = 2'b00,
    FC_DATA  = 2'b01,
    FC_START = 2'b10,
    FC_LAST  = 2'b11
  } fcode_e;

  localparam int CNT_W  = 26;
  localparam int BYTES_PER_WORD = 2;

  typedef struct packed {
    logic             started;
    logic             done;
    logic             full;
    logic             empty;
    logic             mode;
    logic             running;
    logic [CNT_W-1:0] bytes;
  } status_t;

  function automatic logic [CNT_W-1:0] count_step(input logic [CNT_W-1:0] c);
    return c + CNT_W'(BYTES_PER_WORD);
  endfunction

  function automatic logic [31:0] pack_status(input status_t s);
    return 32'(s);
  endfunction

endpackage

// File: rtl/frx_decode.sv
module frx_decode
  import frx_pkg::*;
(
  input  logic [1:0] code,
  output logic       is_payload,
  output logic       is_start,
  output logic       is_last
);
  fcode_e fc;

  always_comb begin
    fc         = fcode_e'(code);
    is_payload = (fc != FC_IDLE);
    is_start   = (fc == FC_START);
    is_last    = (fc == FC_LAST);
  end
endmodule

// File: rtl/frx_fifo.sv
module frx_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          full,
  output logic          empty,
  output logic          wr_accept,
  output logic          wr_drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW:0] FULL_LVL = (AW+1)'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW:0]   wp, rp, level;
  logic          rd_do;

  assign level     = wp - rp;
  assign full      = (level == FULL_LVL);
  assign empty     = (level == '0);
  assign wr_accept = wr_req && !full;
  assign wr_drop   = wr_req && full;
  assign rd_do     = rd_en && !empty;
  assign rd_data   = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (wr_accept) begin
        mem[wp[AW-1:0]] <= wr_data;
        wp <= wp + 1'b1;
      end
      if (rd_do) rp <= rp + 1'b1;
    end
  end
endmodule

// File: rtl/frx_track.sv
module frx_track
  import frx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_accept,
  input  logic             wr_drop,
  input  logic             is_start,
  input  logic             is_last,
  output logic [CNT_W-1:0] byte_cnt,
  output logic             started,
  output logic             done,
  output logic             running,
  output logic             sof_pulse,
  output logic             eof_pulse,
  output logic             ovf_seen
);
  logic start_ev, last_ev;

  assign start_ev = wr_accept && is_start;
  assign last_ev  = wr_accept && is_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      byte_cnt  <= '0;
      started   <= 1'b0;
      done      <= 1'b0;
      running   <= 1'b0;
      sof_pulse <= 1'b0;
      eof_pulse <= 1'b0;
      ovf_seen  <= 1'b0;
    end else begin
      if (wr_accept) byte_cnt <= count_step(byte_cnt);
      if (start_ev) begin
        started <= 1'b1;
        running <= 1'b1;
        done    <= 1'b0;
      end
      if (last_ev) begin
        done    <= 1'b1;
        running <= 1'b0;
      end
      sof_pulse <= start_ev;
      eof_pulse <= last_ev;
      if (wr_drop) ovf_seen <= 1'b1;
    end
  end
endmodule

// File: rtl/frame_rx.sv
module frame_rx
  import frx_pkg::*;
#(
  parameter int DW    = 16,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    in_code,
  input  logic [DW-1:0] in_data,
  input  logic          mode_dma,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic [31:0]   status,
  output logic          sof_pulse,
  output logic          eof_pulse,
  output logic          ovf_seen
);
  logic             is_payload, is_start, is_last;
  logic             fifo_full, fifo_empty, wr_accept, wr_drop;
  logic [CNT_W-1:0] byte_cnt;
  logic             started, done, running;
  status_t          st;

  frx_decode u_dec (
    .code(in_code), .is_payload(is_payload),
    .is_start(is_start), .is_last(is_last)
  );

  frx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .wr_req(is_payload), .wr_data(in_data),
    .rd_en(rd_en), .rd_data(rd_data), .full(fifo_full), .empty(fifo_empty),
    .wr_accept(wr_accept), .wr_drop(wr_drop)
  );

  frx_track u_trk (
    .clk(clk), .rst(rst), .wr_accept(wr_accept), .wr_drop(wr_drop),
    .is_start(is_start), .is_last(is_last), .byte_cnt(byte_cnt),
    .started(started), .done(done), .running(running),
    .sof_pulse(sof_pulse), .eof_pulse(eof_pulse), .ovf_seen(ovf_seen)
  );

  always_comb begin
    st.started = started;
    st.done    = done;
    st.full    = fifo_full;
    st.empty   = fifo_empty;
    st.mode    = mode_dma;
    st.running = running;
    st.bytes   = byte_cnt;
  end

  assign status   = pack_status(st);
  assign rd_valid = !fifo_empty;
endmodule

// File: rtl/frx_checker.sv
module frx_checker (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  in_code,
  input logic        wr_accept,
  input logic        wr_drop,
  input logic [31:0] status,
  input logic        sof_pulse,
  input logic        eof_pulse,
  input logic        ovf_seen
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (status[25:0] == 26'd0 && status[28] && !status[30] && !ovf_seen));

  a_r2_idle_no_count: assert property (@(posedge clk) disable iff (rst)
    (in_code == 2'b00) |=> $stable(status[25:0]));

  a_r4_count_step: assert property (@(posedge clk) disable iff (rst)
    wr_accept |=> (status[25:0] == $past(status[25:0]) + 26'd2));

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
    wr_drop |=> ($stable(status[25:0]) && ovf_seen));

  a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_seen |=> ovf_seen);

  a_r10_full_empty: assert property (@(posedge clk) disable iff (rst)
    !(status[29] && status[28]));

  a_r7_sof_running: assert property (@(posedge clk) disable iff (rst)
    sof_pulse |-> (status[31] && !status[30]));

  a_r8_eof_done: assert property (@(posedge clk) disable iff (rst)
    eof_pulse |-> (status[30] && !status[26]));
endmodule

bind frame_rx frx_checker u_chk (
  .clk(clk), .rst(rst), .in_code(in_code), .wr_accept(wr_accept),
  .wr_drop(wr_drop), .status(status), .sof_pulse(sof_pulse),
  .eof_pulse(eof_pulse), .ovf_seen(ovf_seen)
);

// File: tb/sim_frame_rx.sv
module sim_frame_rx;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  in_code = 2'b00;
  logic [15:0] in_data = '0;
  logic        mode_dma = 1'b0;
  logic        rd_en = 1'b0;
  logic [15:0] rd_data;
  logic        rd_valid;
  logic [31:0] status;
  logic        sof_pulse, eof_pulse, ovf_seen;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frame_rx #(.DW(16), .DEPTH(DEPTH)) u0 (
    .clk(clk), .rst(rst), .in_code(in_code), .in_data(in_data),
    .mode_dma(mode_dma), .rd_en(rd_en), .rd_data(rd_data),
    .rd_valid(rd_valid), .status(status), .sof_pulse(sof_pulse),
    .eof_pulse(eof_pulse), .ovf_seen(ovf_seen)
  );

  function automatic logic [25:0] exp_bytes(input int words);
    return 26'(words * 2);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] c, input logic [15:0] d);
    in_code = c;
    in_data = d;
    @(negedge clk);
    in_code = 2'b00;
    in_data = 16'h0;
  endtask

  task automatic pop(input string req, input logic [15:0] exp);
    check(req, {31'd0, rd_valid}, 32'd1);
    check(req, {16'd0, rd_data}, {16'd0, exp});
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check("R1 status", status, 32'h1000_0000);
    check("R1 rd_valid", {31'd0, rd_valid}, 32'd0);
    check("R1 ovf", {31'd0, ovf_seen}, 32'd0);
    check("R1 strobes", {30'd0, sof_pulse, eof_pulse}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_idle();
    do_reset();
    for (int i = 0; i < 3; i++) send(2'b00, 16'h1234 + 16'(i));
    check("R2 idle count", {6'd0, status[25:0]}, 32'd0);
    check("R2 idle empty", {31'd0, rd_valid}, 32'd0);
    check("R2 idle flags", {26'd0, status[31:26]}, 32'b000100);
  endtask

  task automatic t_block();
    do_reset();
    send(2'b10, 16'h000F);
    check("R7 sof", {31'd0, sof_pulse}, 32'd1);
    check("R7 start flags", {29'd0, status[31], status[30], status[26]}, 32'b101);
    check("R4 one word", {6'd0, status[25:0]}, {6'd0, exp_bytes(1)});
    send(2'b01, 16'h0001);
    check("R7 sof one cycle", {31'd0, sof_pulse}, 32'd0);
    send(2'b00, 16'hBEEF);
    check("R2 idle in block", {6'd0, status[25:0]}, {6'd0, exp_bytes(2)});
    check("R7 running held", {31'd0, status[26]}, 32'd1);
    send(2'b01, 16'h0002);
    send(2'b11, 16'h00F0);
    check("R8 eof", {31'd0, eof_pulse}, 32'd1);
    check("R8 end flags", {29'd0, status[31], status[30], status[26]}, 32'b110);
    check("R4 four words", {6'd0, status[25:0]}, {6'd0, exp_bytes(4)});
    check("R6 packed", status, {6'b110000, exp_bytes(4)});
    @(negedge clk);
    check("R8 eof one cycle", {31'd0, eof_pulse}, 32'd0);
    pop("R3 order", 16'h000F);
    pop("R3 order", 16'h0001);
    pop("R3 order", 16'h0002);
    pop("R3 order", 16'h00F0);
    check("R10 empty after drain", {31'd0, status[28]}, 32'd1);
    send(2'b10, 16'h0AAA);
    check("R7 done cleared", {29'd0, status[31], status[30], status[26]}, 32'b101);
  endtask

  task automatic t_overflow();
    do_reset();
    for (int i = 0; i < DEPTH; i++) begin
      send(2'b01, 16'h0100 + 16'(i));
      if (i == DEPTH - 2) check("R10 not full", {31'd0, status[29]}, 32'd0);
    end
    check("R10 full", {30'd0, status[29], status[28]}, 32'b10);
    check("R4 full count", {6'd0, status[25:0]}, {6'd0, exp_bytes(DEPTH)});
    check("R5 no ovf yet", {31'd0, ovf_seen}, 32'd0);
    send(2'b11, 16'hDEAD);
    check("R5 count held", {6'd0, status[25:0]}, {6'd0, exp_bytes(DEPTH)});
    check("R5 ovf", {31'd0, ovf_seen}, 32'd1);
    check("R5 drop no eof", {31'd0, eof_pulse}, 32'd0);
    in_code = 2'b01;
    in_data = 16'hCAFE;
    rd_en = 1'b1;
    @(negedge clk);
    in_code = 2'b00;
    rd_en = 1'b0;
    check("R5 read+write full", {6'd0, status[25:0]}, {6'd0, exp_bytes(DEPTH)});
    for (int i = 1; i < DEPTH; i++) pop("R5 contents", 16'h0100 + 16'(i));
    check("R5 dropped absent", {31'd0, rd_valid}, 32'd0);
    check("R5 ovf sticky", {31'd0, ovf_seen}, 32'd1);
    do_reset();
    check("R1 ovf cleared", {31'd0, ovf_seen}, 32'd0);
  endtask

  task automatic t_mode();
    do_reset();
    mode_dma = 1'b1;
    @(negedge clk);
    check("R9 dma mode", {31'd0, status[27]}, 32'd1);
    mode_dma = 1'b0;
    @(negedge clk);
    check("R9 program mode", {31'd0, status[27]}, 32'd0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_idle();
    t_block();
    t_overflow();
    t_mode();
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule